// File: doc/BRIEF.md
# Duty-Cycled Omnipolar Magnetic Switch Controller

This block is the digital sequencer behind a low-power magnetic presence switch. An external converter supplies signed field-strength codes on a valid/data port, where south fields are positive and north fields are negative. The block powers the sensor only during short awake windows placed inside a long sleep period. It classifies the samples of each window by field magnitude, with separate operate and release thresholds, and latches the result onto an active-low switch output when the window closes.

The sensor stays powered without a break while the switch output is asserted (low) or while the active-low driver enable is held low. A polarity-select input inverts how a strong or weak field maps onto the output. After reset the output is held high through a startup delay. A full awake window then runs before the first sleep interval. If the field never leaves the hysteresis band, the output stays high whichever polarity is selected.

Top module: `magsw_ctrl`

## Requirements
- R1: While reset is asserted and for START_CYC clock cycles after it is released, `sw_out_n` is 1 and `sense_awake` is 0. `sense_awake` first reads 1 after the START_CYC-th rising edge that follows reset release.
- R2: An awake window lasts AWAKE_CYC cycles. When neither hold condition (R9, R10) is present, it is followed by PERIOD_CYC-AWAKE_CYC cycles with `sense_awake` at 0, and then the next window starts.
- R3: `sw_out_n` changes only on the clock edge that ends an awake window, or when `pol_gnd` changes. Samples presented while `sense_awake` is 0 are ignored. Within one window, samples are applied in order, each one judged against the result of the ones before it.
- R4: The magnitude of a sample is its two's complement absolute value, with negative codes meaning north and the most negative code included. A magnitude strictly greater than OP_TH classifies the field as strong.
- R5: A magnitude strictly less than RL_TH classifies the field as weak. A magnitude from RL_TH to OP_TH inclusive leaves the classification unchanged.
- R6: With `pol_gnd`=0, a strong field drives `sw_out_n` to 0 and a weak field drives it to 1. With `pol_gnd`=1 the mapping is inverted.
- R7: Until the first sample that classifies as strong or weak, `sw_out_n` is 1 for both values of `pol_gnd`.
- R8: A window that ends without any valid sample keeps the previous classification.
- R9: If `sw_out_n` is 0 right after a window ends, a new window starts at once, so `sense_awake` stays 1.
- R10: While `drv_en_n` is 0 after startup, `sense_awake` is 1 from the next cycle on. A sleep interval is cut short, and every window that ends starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| smp_valid | input | 1 | Field sample present this cycle |
| smp_code | input | CODE_W | Signed field code, negative for north |
| drv_en_n | input | 1 | Active-low driver enable; holds the sensor awake |
| pol_gnd | input | 1 | 1 inverts the strong/weak to output mapping |
| sense_awake | output | 1 | Sensor power strobe |
| sw_out_n | output | 1 | Active-low switch output |

## Verification
The bench probes codes at exactly OP_TH, OP_TH+1, RL_TH and RL_TH-1 for both poles, plus the most negative code. An off-by-one comparator would flip the output one code early, and a naive absolute value would read the most negative code as weak. Several samples are sent within one window, and strong samples are sent during sleep. A design that latched each sample immediately, or that listened while asleep, would change the output in the middle of a window or between windows. The bench also checks that an asserted output or a low enable keeps the sensor powered without a gap, that a low enable cuts sleep short on the next cycle, and that a start inside the band holds the output high under either polarity.

// File: rtl/magsw_pkg.sv
package magsw_pkg;

  typedef enum logic [1:0] {
    FS_UNKNOWN = 2'd0,
    FS_STRONG  = 2'd1,
    FS_WEAK    = 2'd2
  } field_st_e;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_AWAKE = 2'd1,
    PH_SLEEP = 2'd2
  } phase_e;

  // Absolute value on one extra bit so the most negative code survives.
  function automatic logic [32:0] fld_mag(input logic signed [31:0] v);
    logic signed [32:0] w;
    w = {v[31], v};
    if (w < 0) w = -w;
    return $unsigned(w);
  endfunction

  // Hysteretic classification of one magnitude against the running state.
  function automatic field_st_e fld_classify(input field_st_e prev,
                                             input logic [32:0] mag,
                                             input logic [32:0] op_th,
                                             input logic [32:0] rl_th);
    field_st_e r;
    r = prev;
    if (mag > op_th) r = FS_STRONG;
    else if (mag < rl_th) r = FS_WEAK;
    return r;
  endfunction

  // Active-low output level for a classification and polarity choice.
  function automatic logic fld_drive_n(input field_st_e st, input logic pol_gnd);
    logic r;
    r = 1'b1;
    if (st == FS_STRONG) r = pol_gnd;
    else if (st == FS_WEAK) r = ~pol_gnd;
    return r;
  endfunction

endpackage

// File: rtl/magsw_sched.sv
module magsw_sched
  import magsw_pkg::*;
#(
  parameter int AWAKE_CYC = 8,
  parameter int SLEEP_CYC = 56,
  parameter int START_CYC = 20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_wake,
  input  logic   hold_req,
  output phase_e phase,
  output logic   win_first,
  output logic   win_end,
  output logic   in_startup
);

  localparam int LIM_A = (AWAKE_CYC > SLEEP_CYC) ? AWAKE_CYC : SLEEP_CYC;
  localparam int LIM   = (LIM_A > START_CYC) ? LIM_A : START_CYC;
  localparam int CNT_W = $clog2(LIM + 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] AWAKE_LAST = CNT_W'(AWAKE_CYC - 1);
  localparam logic [CNT_W-1:0] SLEEP_LAST = CNT_W'(SLEEP_CYC - 1);

  phase_e           ph_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    win_first  = (phase == PH_AWAKE) && (cnt == '0);
    win_end    = (phase == PH_AWAKE) && (cnt == AWAKE_LAST);
    in_startup = (phase == PH_START);
  end

  always_comb begin
    ph_n  = phase;
    cnt_n = cnt + 1'b1;
    unique case (phase)
      PH_START: begin
        if (cnt == START_LAST) begin
          ph_n  = PH_AWAKE;
          cnt_n = '0;
        end
      end
      PH_AWAKE: begin
        if (cnt == AWAKE_LAST) begin
          cnt_n = '0;
          ph_n  = hold_req ? PH_AWAKE : PH_SLEEP;
        end
      end
      PH_SLEEP: begin
        if ((cnt == SLEEP_LAST) || en_wake) begin
          ph_n  = PH_AWAKE;
          cnt_n = '0;
        end
      end
      default: begin
        ph_n  = PH_START;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_START;
      cnt   <= '0;
    end else begin
      phase <= ph_n;
      cnt   <= cnt_n;
    end
  end

endmodule

// File: rtl/magsw_classify.sv
module magsw_classify
  import magsw_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int OP_TH  = 40,
  parameter int RL_TH  = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     awake,
  input  logic                     smp_valid,
  input  logic signed [CODE_W-1:0] smp_code,
  input  logic                     win_first,
  input  logic                     win_end,
  output field_st_e                st_now,
  output field_st_e                st_commit
);

  localparam logic [32:0] OP_MAG = 33'(OP_TH);
  localparam logic [32:0] RL_MAG = 33'(RL_TH);

  field_st_e          pend, pend_base;
  logic signed [31:0] code_x;
  logic               smp_take;

  always_comb begin
    code_x    = 32'(smp_code);
    smp_take  = awake && smp_valid;
    pend_base = win_first ? st_now : pend;
    st_commit = pend_base;
    if (smp_take) st_commit = fld_classify(pend_base, fld_mag(code_x), OP_MAG, RL_MAG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= FS_UNKNOWN;
      st_now <= FS_UNKNOWN;
    end else begin
      if (awake)   pend   <= st_commit;
      if (win_end) st_now <= st_commit;
    end
  end

endmodule

// File: rtl/magsw_ctrl.sv
module magsw_ctrl
  import magsw_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int OP_TH      = 40,
  parameter int RL_TH      = 25,
  parameter int AWAKE_CYC  = 8,
  parameter int PERIOD_CYC = 64,
  parameter int START_CYC  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [CODE_W-1:0] smp_code,
  input  logic                     drv_en_n,
  input  logic                     pol_gnd,
  output logic                     sense_awake,
  output logic                     sw_out_n
);

  localparam int SLEEP_CYC = PERIOD_CYC - AWAKE_CYC;

  phase_e    phase;
  field_st_e st_now, st_commit;
  logic      win_first, win_end, in_startup;
  logic      commit_drive_n, hold_req;

  assign sense_awake    = (phase == PH_AWAKE);
  assign sw_out_n       = fld_drive_n(st_now, pol_gnd);
  assign commit_drive_n = fld_drive_n(st_commit, pol_gnd);
  assign hold_req       = !commit_drive_n || !drv_en_n;

  magsw_sched #(
    .AWAKE_CYC(AWAKE_CYC),
    .SLEEP_CYC(SLEEP_CYC),
    .START_CYC(START_CYC)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wake   (!drv_en_n),
    .hold_req  (hold_req),
    .phase     (phase),
    .win_first (win_first),
    .win_end   (win_end),
    .in_startup(in_startup)
  );

  magsw_classify #(
    .CODE_W(CODE_W),
    .OP_TH (OP_TH),
    .RL_TH (RL_TH)
  ) u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .awake    (sense_awake),
    .smp_valid(smp_valid),
    .smp_code (smp_code),
    .win_first(win_first),
    .win_end  (win_end),
    .st_now   (st_now),
    .st_commit(st_commit)
  );

endmodule

// File: rtl/magsw_ctrl_chk.sv
module magsw_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic drv_en_n,
  input logic pol_gnd,
  input logic sense_awake,
  input logic sw_out_n,
  input logic in_startup,
  input logic win_end,
  input logic commit_drive_n
);

  assert_startup_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_startup |-> (sw_out_n && !sense_awake));

  assert_out_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(sw_out_n) || !$stable(pol_gnd)));

  assert_asleep_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_awake |=> ($stable(sw_out_n) || !$stable(pol_gnd)));

  assert_on_keeps_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !commit_drive_n) |=> sense_awake);

  assert_enable_keeps_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en_n && !in_startup) |=> sense_awake);

endmodule

bind magsw_ctrl magsw_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .drv_en_n      (drv_en_n),
  .pol_gnd       (pol_gnd),
  .sense_awake   (sense_awake),
  .sw_out_n      (sw_out_n),
  .in_startup    (in_startup),
  .win_end       (win_end),
  .commit_drive_n(commit_drive_n)
);

// File: tb/magsw_ctrl_bench.sv
module magsw_ctrl_bench;

  localparam int CW  = 12;
  localparam int OP  = 40;
  localparam int RL  = 25;
  localparam int AW  = 8;
  localparam int PER = 64;
  localparam int ST  = 20;
  localparam int SL  = PER - AW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 smp_valid = 1'b0;
  logic signed [CW-1:0] smp_code = '0;
  logic                 drv_en_n = 1'b1;
  logic                 pol_gnd = 1'b0;
  logic                 sense_awake, sw_out_n;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  logic  b_en = 1'b1, b_pol = 1'b0;
  bit    done = 0;

  // bench model state: phase 0 start, 1 awake, 2 sleep; class 0 unknown, 1 strong, 2 weak
  int m_ph = 0, m_cnt = 0, m_st = 0, m_pend = 0;

  always #5 clk = ~clk;

  magsw_ctrl #(
    .CODE_W(CW), .OP_TH(OP), .RL_TH(RL),
    .AWAKE_CYC(AW), .PERIOD_CYC(PER), .START_CYC(ST)
  ) u_magsw_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .drv_en_n(drv_en_n), .pol_gnd(pol_gnd),
    .sense_awake(sense_awake), .sw_out_n(sw_out_n)
  );

  function automatic int b_class(input int prev, input int code);
    int m;
    m = (code < 0) ? -code : code;
    if (m > OP) return 1;
    if (m < RL) return 2;
    return prev;
  endfunction

  function automatic logic b_out(input int st, input logic pol);
    if (st == 1) return pol;
    if (st == 2) return !pol;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    int base;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_st = 0; m_pend = 0;
    end else begin
      case (m_ph)
        0: if (m_cnt == ST - 1) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
        1: begin
          base = (m_cnt == 0) ? m_st : m_pend;
          if (smp_valid) base = b_class(base, int'(smp_code));
          m_pend = base;
          if (m_cnt == AW - 1) begin
            m_st  = base;
            m_cnt = 0;
            m_ph  = (!b_out(m_st, pol_gnd) || !drv_en_n) ? 1 : 2;
          end else m_cnt++;
        end
        default: if (m_cnt == SL - 1 || !drv_en_n) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
      endcase
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, advance one cycle, compare with the model
  task automatic cyc(input logic v, input int code);
    smp_valid = v; smp_code = CW'(code); drv_en_n = b_en; pol_gnd = b_pol;
    @(negedge clk);
    chk(sense_awake, (m_ph == 1), cur_req, "awake vs model");
    chk(sw_out_n, b_out(m_st, pol_gnd), cur_req, "out vs model");
  endtask

  task automatic idle();
    cyc(1'b0, 0);
  endtask

  task automatic wait_awake();
    int k;
    k = 0;
    while (!sense_awake && k < 500) begin idle(); k++; end
  endtask

  task automatic window(input int code);
    wait_awake();
    for (int i = 0; i < AW; i++) cyc(1'b1, code);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(sw_out_n, 1'b1, "R1", "out in reset");
    chk(sense_awake, 1'b0, "R1", "awake in reset");
    rst_n = 1'b1;
    n = 0;
    while (!sense_awake && n < 1000) begin cyc(1'b1, 60); n++; end
    chk_int(n, ST, "R1", "startup length");
    chk(sw_out_n, 1'b1, "R1", "out high at end of startup");

    cur_req = "R7";
    window(30);
    chk(sw_out_n, 1'b1, "R7", "in-band start, pol float");
    chk(sense_awake, 1'b0, "R2", "sleep after first window");
    b_pol = 1'b1;
    cur_req = "R2";
    n = 0;
    while (!sense_awake && n < 500) begin idle(); n++; end
    chk_int(n, SL, "R2", "sleep length");
    chk(sw_out_n, 1'b1, "R7", "in-band start, pol gnd");
    b_pol = 1'b0;
    n = 0;
    while (sense_awake && n < 500) begin idle(); n++; end
    chk_int(n, AW, "R2", "window length");
    chk(sw_out_n, 1'b1, "R8", "empty window keeps unknown");

    cur_req = "R4";
    window(41);
    chk(sw_out_n, 1'b0, "R4", "south 41 strong");
    chk(sense_awake, 1'b1, "R9", "awake while on");
    cur_req = "R9";
    window(41);
    chk(sense_awake, 1'b1, "R9", "still awake while on");
    cur_req = "R5";
    window(25);
    chk(sw_out_n, 1'b0, "R5", "25 equal release keeps on");
    window(40);
    chk(sw_out_n, 1'b0, "R5", "40 equal operate keeps on");
    window(24);
    chk(sw_out_n, 1'b1, "R5", "24 releases");
    chk(sense_awake, 1'b0, "R2", "sleeps once off");
    cur_req = "R4";
    window(-40);
    chk(sw_out_n, 1'b1, "R4", "north -40 not strong");
    window(-41);
    chk(sw_out_n, 1'b0, "R4", "north -41 strong");
    window(-2048);
    chk(sw_out_n, 1'b0, "R4", "most negative code strong");
    window(0);
    chk(sw_out_n, 1'b1, "R4", "zero weak");

    cur_req = "R6";
    b_pol = 1'b1;
    idle();
    chk(sw_out_n, 1'b0, "R6", "weak with pol gnd");
    window(50);
    chk(sw_out_n, 1'b1, "R6", "strong with pol gnd");
    chk(sense_awake, 1'b0, "R6", "strong with pol gnd sleeps");
    window(5);
    chk(sw_out_n, 1'b0, "R6", "weak with pol gnd asserts");
    chk(sense_awake, 1'b1, "R9", "awake while asserted, pol gnd");
    b_pol = 1'b0;
    window(5);
    chk(sw_out_n, 1'b1, "R6", "weak with pol float");

    cur_req = "R8";
    wait_awake();
    for (int i = 0; i < AW; i++) idle();
    chk(sw_out_n, 1'b1, "R8", "empty window keeps off");
    window(60);
    for (int i = 0; i < AW; i++) idle();
    chk(sw_out_n, 1'b0, "R8", "empty window keeps on");
    window(0);
    chk(sw_out_n, 1'b1, "R8", "release after empty window");

    cur_req = "R10";
    repeat (5) idle();
    chk(sense_awake, 1'b0, "R10", "asleep before enable");
    b_en = 1'b0;
    idle();
    chk(sense_awake, 1'b1, "R10", "enable wakes next cycle");
    repeat (3 * AW) idle();
    chk(sense_awake, 1'b1, "R10", "enable keeps awake");
    b_en = 1'b1;
    n = 0;
    while (sense_awake && n < 100) begin idle(); n++; end
    chk(sense_awake, 1'b0, "R10", "sleeps after enable released");

    cur_req = "R3";
    n = 0;
    while (!sense_awake && n < 500) begin cyc(1'b1, 70); n++; end
    chk(sw_out_n, 1'b1, "R3", "sleep samples ignored");
    cyc(1'b1, 50);
    chk(sw_out_n, 1'b1, "R3", "no change mid window");
    cyc(1'b1, 50);
    for (int i = 0; i < AW - 2; i++) cyc(1'b1, 30);
    chk(sw_out_n, 1'b0, "R3", "in-band after strong keeps strong");
    cyc(1'b1, 50);
    for (int i = 0; i < AW - 1; i++) cyc(1'b1, 10);
    chk(sw_out_n, 1'b1, "R3", "last weak sample wins");

    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      int code;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 2) b_en = !b_en;
      if (r == 50) b_pol = !b_pol;
      code = int'($urandom_range(0, 180)) - 90;
      if (r == 77) code = -2048;
      if (r == 78) code = 2047;
      cyc($urandom_range(0, 3) != 0, code);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule